// File: doc/BRIEF.md
# Dual Reference Switchover Controller

This block decides which of two reference clocks, A or B, drives a downstream phase-locked loop. Both references are treated as asynchronous inputs. Each one is synchronised into the system clock domain, and its rising edges are counted against a programmable observation window. The result is a registered presence flag for each reference.

A small selection state machine reads the two presence flags and decides whether A or B is active. When neither reference can be used, it raises a holdover flag. In automatic mode it falls back to the backup reference when the active one disappears. A configuration input chooses what happens when A comes back while B is active: either return to A, or stay on B. A manual mode lets a select input dictate the choice directly. After every change of selection or holdover state, further changes are blocked for a settle interval. A one-cycle pulse marks each change of the select output.

Top module: `refsw_ctrl`

## Requirements
- R1: A reference is reported present (pres_a / pres_b high) once rising edges are seen in every window of WIN_CYCLES system cycles. It is reported absent after a full window passes with no rising edge.
- R2: While reset is held and directly after it, sel_b is 0 (A), holdover is 1, pres_a and pres_b are 0, and switch_pulse is 0.
- R3: In automatic mode (man_en=0), when both references become present after reset, A is active (sel_b=0) and holdover is 0.
- R4: In automatic mode, when only one reference is present, that reference is active and holdover is 0.
- R5: In automatic mode, when the active reference fails and the other one is present, sel_b moves to the other reference.
- R6: With revert_en=1, if A returns while B is active, sel_b goes back to 0.
- R7: With revert_en=0, if A returns while B is active and B is still present, sel_b stays at 1.
- R8: In automatic mode, holdover rises only when both references are absent, and sel_b keeps its value during holdover.
- R9: In automatic mode, holdover is left as soon as any reference is present. The new selection is A if A is present, otherwise B.
- R10: In manual mode (man_en=1), sel_b follows man_sel (0 selects A, 1 selects B). Holdover is 1 exactly when the selected reference is absent.
- R11: Two consecutive changes of (sel_b, holdover) are at least SETTLE_CYCLES system cycles apart.
- R12: switch_pulse is high for exactly the one cycle in which a new sel_b value first appears. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_a_in | input | 1 | Reference clock A (asynchronous) |
| ref_b_in | input | 1 | Reference clock B (asynchronous) |
| revert_en | input | 1 | 1: return to A when it recovers; 0: stay on B |
| man_en | input | 1 | 1: manual selection mode |
| man_sel | input | 1 | Manual choice, 0 = A, 1 = B |
| sel_b | output | 1 | Active reference, 0 = A, 1 = B |
| holdover | output | 1 | No usable reference is selected |
| pres_a | output | 1 | Reference A detected present |
| pres_b | output | 1 | Reference B detected present |
| switch_pulse | output | 1 | One-cycle strobe when sel_b changes |

## Verification
The assertions check the cycle-level rules on every cycle: the spacing between state changes, the pairing of the pulse with a change of select, holdover being entered in automatic mode only when both references are gone, and automatic switches always landing on a reference that was present.

Other behaviours can only be shown by the bench's scenarios. These are the revert and non-revert policy, the choice made when leaving holdover, manual-mode following, and the window-based presence detection. The bench reaches them with randomly timed reference clocks that it switches on and off one input at a time, and compares the settled outputs against a reference model.

// File: rtl/refsw_ctrl.sv
module refsw_ctrl #(
  parameter int WIN_CYCLES    = 16,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_a_in,
  input  logic ref_b_in,
  input  logic revert_en,
  input  logic man_en,
  input  logic man_sel,
  output logic sel_b,
  output logic holdover,
  output logic pres_a,
  output logic pres_b,
  output logic switch_pulse
);
  localparam int WW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam int SW = $clog2(SETTLE_CYCLES + 2);

  logic [2:0] sync_a, sync_b;
  logic [WW-1:0] win_cnt;
  logic seen_a, seen_b;
  logic [SW-1:0] settle_cnt;
  logic want_sel, want_hold;

  wire edge_a  = sync_a[1] & ~sync_a[2];
  wire edge_b  = sync_b[1] & ~sync_b[2];
  wire win_end = (win_cnt == WW'(WIN_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a  <= '0;
      sync_b  <= '0;
      win_cnt <= '0;
      seen_a  <= 1'b0;
      seen_b  <= 1'b0;
      pres_a  <= 1'b0;
      pres_b  <= 1'b0;
    end else begin
      sync_a  <= {sync_a[1:0], ref_a_in};
      sync_b  <= {sync_b[1:0], ref_b_in};
      win_cnt <= win_end ? '0 : win_cnt + 1'b1;
      seen_a  <= win_end ? 1'b0 : (seen_a | edge_a);
      seen_b  <= win_end ? 1'b0 : (seen_b | edge_b);
      if (win_end) begin
        pres_a <= seen_a | edge_a;
        pres_b <= seen_b | edge_b;
      end
    end
  end

  always_comb begin
    want_sel  = sel_b;
    want_hold = holdover;
    if (man_en) begin
      want_sel  = man_sel;
      want_hold = man_sel ? !pres_b : !pres_a;
    end else if (!pres_a && !pres_b) begin
      want_hold = 1'b1;
    end else if (holdover) begin
      want_hold = 1'b0;
      want_sel  = !pres_a;
    end else if (!sel_b) begin
      if (!pres_a && pres_b) want_sel = 1'b1;
    end else begin
      if (pres_a && (!pres_b || revert_en)) want_sel = 1'b0;
    end
  end

  wire differ = (want_sel != sel_b) || (want_hold != holdover);
  wire take   = differ && (settle_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_b        <= 1'b0;
      holdover     <= 1'b1;
      settle_cnt   <= '0;
      switch_pulse <= 1'b0;
    end else begin
      switch_pulse <= take && (want_sel != sel_b);
      if (take) begin
        sel_b      <= want_sel;
        holdover   <= want_hold;
        settle_cnt <= SW'(SETTLE_CYCLES);
      end else if (settle_cnt != '0) begin
        settle_cnt <= settle_cnt - 1'b1;
      end
    end
  end

  // Checker state: observed changes and the gap since the last one
  logic prev_sel, prev_hold;
  logic [SW-1:0] gap_cnt;
  wire chg_seen = (sel_b != prev_sel) || (holdover != prev_hold);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sel  <= 1'b0;
      prev_hold <= 1'b1;
      gap_cnt   <= SW'(SETTLE_CYCLES);
    end else begin
      prev_sel  <= sel_b;
      prev_hold <= holdover;
      if (chg_seen) gap_cnt <= '0;
      else if (gap_cnt < SW'(SETTLE_CYCLES)) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assert_settle_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chg_seen |-> (gap_cnt >= SW'(SETTLE_CYCLES)));

  assert_pulse_on_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b != prev_sel) |-> switch_pulse);

  assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |=> !switch_pulse);

  assert_hold_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover && !prev_hold) |-> ($past(man_en) || (!$past(pres_a) && !$past(pres_b))));

  assert_auto_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_b != prev_sel) && !holdover && !$past(man_en)) |->
      (sel_b ? $past(pres_b) : $past(pres_a)));

endmodule

// File: tb/refsw_ctrl_tb.sv
`timescale 1ns/1ps
module refsw_ctrl_tb_top;
  localparam int WIN = 16;
  localparam int SET = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_a_in = 1'b0, ref_b_in = 1'b0;
  logic revert_en = 1'b0, man_en = 1'b0, man_sel = 1'b0;
  logic sel_b, holdover, pres_a, pres_b, switch_pulse;

  int checks = 0, errors = 0;
  bit en_a = 0, en_b = 0;
  int half_a = 12, half_b = 17;
  logic m_sel = 1'b0, m_hold = 1'b1;

  refsw_ctrl #(.WIN_CYCLES(WIN), .SETTLE_CYCLES(SET)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_a_in(ref_a_in), .ref_b_in(ref_b_in),
    .revert_en(revert_en), .man_en(man_en), .man_sel(man_sel),
    .sel_b(sel_b), .holdover(holdover), .pres_a(pres_a), .pres_b(pres_b),
    .switch_pulse(switch_pulse));

  always #2 clk = ~clk;
  always begin #(half_a); if (en_a) ref_a_in = ~ref_a_in; end
  always begin #(half_b); if (en_b) ref_b_in = ~ref_b_in; end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic s, input logic h, input bit pa, input bit pb);
    logic [1:0] r;
    r = {s, h};
    for (int k = 0; k < 3; k++) begin
      if (man_en) r = {man_sel, man_sel ? !pb : !pa};
      else if (!pa && !pb) r = {r[1], 1'b1};
      else if (r[0]) r = {!pa, 1'b0};
      else if (!r[1]) r = {(!pa && pb), 1'b0};
      else r = {!(pa && (!pb || revert_en)), 1'b0};
    end
    return r;
  endfunction

  // Monitor for spacing and pulse behaviour
  logic pv_sel = 1'b0, pv_hold = 1'b1;
  int gap = 1000;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sel_b != pv_sel || holdover != pv_hold) begin
        chk("R11", "gap between changes >= settle", (gap >= SET) ? 1 : 0, 1);
        gap = 0;
      end else gap++;
      if (sel_b != pv_sel || switch_pulse)
        chk("R12", "pulse matches select change", switch_pulse, (sel_b != pv_sel) ? 1 : 0);
    end
    pv_sel = sel_b;
    pv_hold = holdover;
  end

  task automatic settle_and_check(input string req);
    logic [1:0] e;
    repeat (130) @(negedge clk);
    e = model(m_sel, m_hold, en_a, en_b);
    m_sel = e[1];
    m_hold = e[0];
    chk("R1", "pres_a", pres_a, en_a);
    chk("R1", "pres_b", pres_b, en_b);
    chk(req, "sel_b", sel_b, m_sel);
    chk(req, "holdover", holdover, m_hold);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2", "sel_b in reset", sel_b, 0);
    chk("R2", "holdover in reset", holdover, 1);
    chk("R2", "pres_a in reset", pres_a, 0);
    chk("R2", "pres_b in reset", pres_b, 0);
    chk("R2", "pulse in reset", switch_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "sel_b after reset", sel_b, 0);
    chk("R2", "holdover after reset", holdover, 1);

    en_a = 1; en_b = 1; settle_and_check("R3");
    chk("R3", "A active with both present", sel_b, 0);
    en_a = 0; settle_and_check("R5");
    chk("R5", "moved to B", sel_b, 1);
    revert_en = 0; en_a = 1; settle_and_check("R7");
    chk("R7", "stays on B", sel_b, 1);
    revert_en = 1; settle_and_check("R6");
    chk("R6", "reverted to A", sel_b, 0);
    en_b = 0; settle_and_check("R4");
    en_a = 0; settle_and_check("R8");
    chk("R8", "holdover with none present", holdover, 1);
    chk("R8", "select kept in holdover", sel_b, 0);
    en_b = 1; settle_and_check("R9");
    chk("R9", "exit holdover to B", sel_b, 1);
    chk("R4", "only B present -> B", sel_b, 1);
    en_a = 1; revert_en = 0; settle_and_check("R7");
    man_en = 1; man_sel = 0; settle_and_check("R10");
    chk("R10", "manual select A", sel_b, 0);
    // rapid manual flip to exercise settle spacing
    man_sel = 1; repeat (2) @(negedge clk); man_sel = 0; repeat (2) @(negedge clk);
    man_sel = 1; settle_and_check("R10");
    chk("R10", "manual select B", sel_b, 1);
    en_b = 0; settle_and_check("R10");
    chk("R10", "manual holdover on absent B", holdover, 1);
    man_en = 0; settle_and_check("R9");

    for (int i = 0; i < 120; i++) begin
      int pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0: begin half_a = $urandom_range(10, 24); en_a = !en_a; end
        1: begin half_b = $urandom_range(10, 24); en_b = !en_b; end
        2: revert_en = !revert_en;
        3: man_en = !man_en;
        4: man_sel = !man_sel;
        default: begin half_a = $urandom_range(10, 24); half_b = $urandom_range(10, 24); end
      endcase
      settle_and_check(man_en ? "R10" : "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(190000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule